// File: doc/BRIEF.md
# Two-Wire Serial Register Slave with Strapped Address

This block is a slave-only two-wire serial port that lets an external bus master write and read a small file of byte-wide configuration registers. The serial clock and data lines are resynchronised to a fast system clock and decoded there. That system clock must be at least twenty times the serial clock, and the serial clock may run at up to 400 kHz. The open-drain data pad lies outside the block. The block only raises `sda_oe` when the line must be pulled low. The register contents are presented in parallel on `cfg_flat` to the logic they configure.

The 7-bit device address has a fixed all-zero upper part, and the three board strap inputs fill its low bits. A write carries the device address with the direction bit clear, then one byte that loads the internal register pointer, then any number of data bytes. A read first sets the pointer with a write, then uses a repeated START with the direction bit set. The pointer steps by one after every data byte in either direction.

A level chip-select holds the port in its idle state while it is low. The active-low sleep input clears the serial engine and every register to its reset value.

The controller is a single state machine with these states:
- `ST_IDLE`: the port waits for a START.
- `ST_DEVADR`: the port shifts in the address byte.
- `ST_ACK_DEV`: the port acknowledges the address.
- `ST_PTR`: the port shifts in the pointer byte.
- `ST_ACK_PTR`: the port acknowledges the pointer.
- `ST_WDAT`: the port shifts in a data byte.
- `ST_ACK_WDAT`: the port acknowledges the data byte.
- `ST_RDAT`: the port shifts a register out.
- `ST_RACK`: the port samples the master's acknowledge.
- `ST_SKIP`: the port ignores the bus.

The transitions are as follows:
- STOP or a low chip-select leads to `ST_IDLE` from any state.
- START leads to `ST_DEVADR` from any state.
- From `ST_DEVADR`, the eighth falling edge goes to `ST_ACK_DEV` on an address match and to `ST_SKIP` otherwise.
- From `ST_ACK_DEV`, the falling edge goes to `ST_RDAT` for a read and to `ST_PTR` for a write.
- `ST_PTR` goes to `ST_ACK_PTR`, which goes to `ST_WDAT`.
- `ST_WDAT` and `ST_ACK_WDAT` alternate.
- `ST_RDAT` goes to `ST_RACK`.
- From `ST_RACK`, a master ACK returns to `ST_RDAT` and a NACK goes to `ST_SKIP`.

Top module: `tws_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal {4'b0000, addr_strap[2:0]}. Bit 0 of that byte is the direction bit: 0 means write and 1 means read.
- R2: The slave does not acknowledge any other address. It keeps SDA released and ignores every later byte until the next START or STOP, so no register changes.
- R3: A write transaction updates a register. The transaction is START, address with write, pointer byte, data byte, STOP. It sets register[pointer] to the data byte, and that byte appears at cfg_flat[8*pointer +: 8], which changes only while SCL is low.
- R4: In a write, every data byte after the pointer byte is acknowledged and stored at the current pointer. The pointer then increases by one, with no limit on the number of bytes.
- R5: A read returns register[pointer] most significant bit first and increases the pointer after each byte. After a master NACK the slave leaves SDA released until the next START or STOP.
- R6: A repeated START without a STOP restarts address matching and keeps the pointer.
- R7: While bus_sel is low the slave acknowledges nothing, drives nothing and writes no register.
- R8: While sleep_n is low, every register holds its reset value of 0x00 and sda_oe is 0.
- R9: sda_oe changes only while SCL is low. An acknowledge is held low over the whole high phase of the acknowledge clock.
- R10: Pointer values at or above the register count read as 0x00, and writes to them are dropped.
- R11: After reset, sda_oe is 0 and cfg_flat is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x SCL |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sleep_n | input | 1 | Active-low sleep; clears engine and registers |
| bus_sel | input | 1 | Chip-select level; low disables the port |
| addr_strap | input | 3 | Low three bits of the device address |
| scl_in | input | 1 | Serial clock from the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_flat | output | NREG*8 | All registers, register i at bits [8i+7:8i] |

## Verification
The hardest case to reach from the ports is the boundary between transactions. This covers a repeated START that arrives while the slave is still addressed, and a master NACK on a read followed by more clocks with no STOP. Both need exact control of SDA against SCL. The bench therefore drives the bus through its own open-drain model, bit by bit, with START, repeated START and STOP as separate tasks. It chains them to switch from a matched write to a mismatched address inside one transaction. It also clocks a full byte after a NACK, and that byte must read back as all ones. An address sweep covers every strap value against all eight low-address values and one address with a non-zero upper part.

// File: rtl/tws_pkg.sv
package tws_pkg;

    // Width of a device address on the bus.
    localparam int ADDR_W = 7;
    // Register and serial byte width.
    localparam int BYTE_W = 8;

    // Bus events extracted by the synchroniser.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda_lvl;
    } tws_evt_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_ACK_DEV,
        ST_PTR,
        ST_ACK_PTR,
        ST_WDAT,
        ST_ACK_WDAT,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync
    import tws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_in,
    input  logic     sda_in,
    output tws_evt_t evt
);

    // STAGES flops of resynchronisation plus one history flop per line.
    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_in};
            sda_p <= {sda_p[STAGES-1:0], sda_in};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_p[STAGES-1];
    assign scl_old = scl_p[STAGES];
    assign sda_now = sda_p[STAGES-1];
    assign sda_old = sda_p[STAGES];

    always_comb begin
        evt.scl_rise = scl_now & ~scl_old;
        evt.scl_fall = ~scl_now & scl_old;
        evt.start    = scl_now & scl_old & sda_old & ~sda_now;
        evt.stop     = scl_now & scl_old & ~sda_old & sda_now;
        evt.sda_lvl  = sda_now;
    end

endmodule

// File: rtl/tws_engine.sv
module tws_engine
    import tws_pkg::*;
#(
    parameter int STRAP_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic [STRAP_W-1:0] strap,
    input  tws_evt_t           evt,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic [BYTE_W-1:0]  ptr,
    output logic               wr_en,
    output logic [BYTE_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               sda_oe
);

    localparam int CNT_W = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    tws_state_e          state_q, state_d;
    logic [BYTE_W-1:0]   shift_q;
    logic [BYTE_W-1:0]   tx_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                rw_q;
    logic                nack_q;

    logic byte_done;
    logic addr_hit;

    assign byte_done = (cnt_q == LAST_BIT);
    // Upper address bits are a fixed zero prefix; the straps fill the rest.
    assign addr_hit  = (shift_q[BYTE_W-1:1] == ADDR_W'(strap));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (!cs || evt.stop) begin
            state_d = ST_IDLE;
        end else if (evt.start) begin
            state_d = ST_DEVADR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_DEVADR:
                    if (evt.scl_fall && byte_done)
                        state_d = addr_hit ? ST_ACK_DEV : ST_SKIP;
                ST_ACK_DEV:
                    if (evt.scl_fall) state_d = rw_q ? ST_RDAT : ST_PTR;
                ST_PTR:
                    if (evt.scl_fall && byte_done) state_d = ST_ACK_PTR;
                ST_ACK_PTR:
                    if (evt.scl_fall) state_d = ST_WDAT;
                ST_WDAT:
                    if (evt.scl_fall && byte_done) state_d = ST_ACK_WDAT;
                ST_ACK_WDAT:
                    if (evt.scl_fall) state_d = ST_WDAT;
                ST_RDAT:
                    if (evt.scl_fall && byte_done) state_d = ST_RACK;
                ST_RACK:
                    if (evt.scl_fall) state_d = nack_q ? ST_SKIP : ST_RDAT;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Output and datapath process; every SDA change happens on an SCL fall.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            tx_q    <= '0;
            cnt_q   <= '0;
            rw_q    <= 1'b0;
            nack_q  <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (!cs || evt.stop || evt.start) begin
                sda_oe <= 1'b0;
                cnt_q  <= '0;
            end else begin
                unique case (state_q)
                    ST_DEVADR, ST_PTR, ST_WDAT: begin
                        if (evt.scl_rise) begin
                            shift_q <= {shift_q[BYTE_W-2:0], evt.sda_lvl};
                            cnt_q   <= cnt_q + 1'b1;
                        end
                        if (evt.scl_fall && byte_done) begin
                            cnt_q  <= '0;
                            sda_oe <= 1'b1;
                            if (state_q == ST_DEVADR) begin
                                rw_q   <= shift_q[0];
                                sda_oe <= addr_hit;
                            end else if (state_q == ST_PTR) begin
                                ptr <= shift_q;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shift_q;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_ACK_DEV: begin
                        if (evt.scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                tx_q   <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_ACK_PTR, ST_ACK_WDAT: begin
                        if (evt.scl_fall) sda_oe <= 1'b0;
                    end
                    ST_RDAT: begin
                        if (evt.scl_rise) cnt_q <= cnt_q + 1'b1;
                        if (evt.scl_fall) begin
                            if (byte_done) begin
                                cnt_q  <= '0;
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                            end else begin
                                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) nack_q <= evt.sda_lvl;
                        if (evt.scl_fall) begin
                            cnt_q <= '0;
                            if (!nack_q) begin
                                tx_q   <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_IDLE, ST_SKIP: sda_oe <= 1'b0;
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/tws_regfile.sv
module tws_regfile
    import tws_pkg::*;
#(
    parameter int                NREG    = 8,
    parameter logic [BYTE_W-1:0] RST_VAL = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [BYTE_W-1:0]        wr_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [BYTE_W-1:0]        rd_addr,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [NREG*BYTE_W-1:0]   cfg_flat
);

    logic [BYTE_W-1:0] regs [NREG];

    // One storage byte per register; addresses past NREG never match.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= RST_VAL;
            else if (wr_en && (wr_addr == BYTE_W'(g)))
                regs[g] <= wr_data;
        end
        assign cfg_flat[g*BYTE_W +: BYTE_W] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == BYTE_W'(i)) rd_data = regs[i];
        end
    end

endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave
    import tws_pkg::*;
#(
    parameter int                NREG        = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] RST_VAL     = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep_n,
    input  logic                   bus_sel,
    input  logic [2:0]             addr_strap,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    output logic [NREG*BYTE_W-1:0] cfg_flat
);

    // Sleep and system reset both clear the whole port.
    logic core_rst_n;
    assign core_rst_n = rst_n & sleep_n;

    tws_evt_t          evt;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;

    tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (core_rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    tws_engine #(.STRAP_W(3)) u_engine (
        .clk     (clk),
        .rst_n   (core_rst_n),
        .cs      (bus_sel),
        .strap   (addr_strap),
        .evt     (evt),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    tws_regfile #(.NREG(NREG), .RST_VAL(RST_VAL)) u_regs (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .cfg_flat (cfg_flat)
    );

endmodule

// File: rtl/tws_reg_slave_chk.sv
module tws_reg_slave_chk #(
    parameter int         NREG    = 8,
    parameter logic [7:0] RST_VAL = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_n,
    input logic              bus_sel,
    input logic              scl_in,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_flat
);

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n || !sleep_n)
        (sda_oe != $past(sda_oe)) |-> !scl_in); // R9

    AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !sleep_n)
        (!bus_sel && !$past(bus_sel)) |-> !sda_oe); // R7

    AST_SLEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |-> (cfg_flat == {NREG{RST_VAL}} && !sda_oe)); // R8

    AST_CFG_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n || !sleep_n)
        (cfg_flat != $past(cfg_flat)) |-> !scl_in); // R3

endmodule

bind tws_reg_slave tws_reg_slave_chk #(.NREG(NREG), .RST_VAL(RST_VAL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_n  (sleep_n),
    .bus_sel  (bus_sel),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .cfg_flat (cfg_flat)
);

// File: tb/tws_reg_slave_bench.sv
module tws_reg_slave_bench;

    localparam int CLK_P = 10;
    localparam int Q     = 10;
    localparam int NREG  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_n = 1'b1;
    logic bus_sel = 1'b1;
    logic [2:0] strap = 3'd0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_flat;
    logic sda_line;

    assign sda_line = sda_drv & ~sda_oe;

    always #(CLK_P/2) clk = ~clk;

    tws_reg_slave #(.NREG(NREG)) u_tws_reg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_n    (sleep_n),
        .bus_sel    (bus_sel),
        .addr_strap (strap),
        .scl_in     (scl),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .cfg_flat   (cfg_flat)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_reg [NREG];
    logic [7:0] txb [16];
    logic [7:0] rxb [16];

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 1'b0; tick(Q);
        sda_drv = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_drv = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; tick(Q);
        sda_drv = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_drv = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input logic b);
        scl = 1'b0; tick(Q);
        sda_drv = b; tick(Q);
        scl = 1'b1; tick(2*Q);
    endtask

    // Releases SDA for one clock; returns 0 only if the line was low throughout high.
    task automatic get_bit(output logic v);
        logic v0, v1;
        scl = 1'b0; tick(Q);
        sda_drv = 1'b1; tick(Q);
        scl = 1'b1; tick(2);
        v0 = sda_line;
        tick(2*Q-3);
        v1 = sda_line;
        tick(1);
        v = v0 | v1;
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        get_bit(v);
        ack = ~v;
    endtask

    task automatic rbyte(output logic [7:0] b, input logic nack);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            b[i] = v;
        end
        send_bit(nack);
    endtask

    task automatic wr_txn(input logic [6:0] dev, input logic [7:0] p, input int n,
                          output int acks);
        logic a;
        acks = 0;
        bus_start();
        wbyte({dev, 1'b0}, a); acks += int'(a);
        wbyte(p, a);           acks += int'(a);
        for (int i = 0; i < n; i++) begin
            wbyte(txb[i], a);  acks += int'(a);
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [6:0] dev, input logic [7:0] p, input int n,
                          output int acks);
        logic a;
        acks = 0;
        bus_start();
        wbyte({dev, 1'b0}, a); acks += int'(a);
        wbyte(p, a);           acks += int'(a);
        bus_start();
        wbyte({dev, 1'b1}, a); acks += int'(a);
        for (int i = 0; i < n; i++) rbyte(rxb[i], (i == n-1));
        bus_stop();
    endtask

    function automatic logic [7:0] exp_at(input int p);
        return (p < NREG) ? exp_reg[p] : 8'h00;
    endfunction

    task automatic check_cfg(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(tag, int'(cfg_flat[i*8 +: 8]), int'(exp_reg[i]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int acks;
        logic a;
        logic [7:0] b;
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R11: reset state
        chk("R11 sda_oe", int'(sda_oe), 0);
        check_cfg("R11 cfg");

        // R1/R2/R9: sweep straps against candidate addresses
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            tick(4);
            for (int lo = 0; lo < 9; lo++) begin
                logic [6:0] dev;
                dev = (lo == 8) ? {4'b0001, 3'(s)} : {4'b0000, 3'(lo)};
                bus_start();
                wbyte({dev, 1'b0}, a);
                bus_stop();
                chk($sformatf("R1 R2 R9 ack strap=%0d dev=%0h", s, dev),
                    int'(a), int'(dev == {4'b0000, 3'(s)}));
            end
        end
        strap = 3'd5;
        tick(4);

        // R3: single-byte writes to every register
        for (int r = 0; r < NREG; r++) begin
            txb[0] = 8'h5A ^ 8'(r * 37);
            exp_reg[r] = txb[0];
            wr_txn(7'h05, 8'(r), 1, acks);
            chk($sformatf("R3 acks reg %0d", r), acks, 3);
        end
        check_cfg("R3 cfg");

        // R2: mismatched address, data must not land
        txb[0] = 8'hEE;
        wr_txn(7'h04, 8'd1, 1, acks);
        chk("R2 ignored acks", acks, 0);
        check_cfg("R2 cfg unchanged");

        // R4: burst across all registers, last bytes past NREG dropped (R10)
        for (int i = 0; i < NREG + 2; i++) txb[i] = 8'(8'hC3 + i * 11);
        for (int i = 2; i < NREG; i++) exp_reg[i] = txb[i-2];
        wr_txn(7'h05, 8'd2, NREG + 2, acks);
        chk("R4 burst acks", acks, NREG + 4);
        check_cfg("R4 R10 burst cfg");

        // R5/R6: burst read from 0 with repeated START, running past NREG (R10)
        rd_txn(7'h05, 8'd0, NREG + 2, acks);
        chk("R5 R6 read acks", acks, 3);
        for (int i = 0; i < NREG + 2; i++)
            chk($sformatf("R5 R10 read byte %0d", i), int'(rxb[i]), int'(exp_at(i)));

        // R5: after NACK the slave stays released for a further byte
        bus_start();
        wbyte({7'h05, 1'b0}, a);
        wbyte(8'd3, a);
        bus_start();
        wbyte({7'h05, 1'b1}, a);
        rbyte(b, 1'b1);
        chk("R5 nack byte", int'(b), int'(exp_reg[3]));
        rbyte(b, 1'b1);
        chk("R5 released after nack", int'(b), 8'hFF);
        bus_stop();

        // R6: repeated START re-runs matching: wrong address then correct read
        bus_start();
        wbyte({7'h05, 1'b0}, a);
        wbyte(8'd6, a);
        bus_start();
        wbyte({7'h01, 1'b1}, a);
        chk("R6 restart mismatch", int'(a), 0);
        bus_start();
        wbyte({7'h05, 1'b1}, a);
        chk("R6 restart match", int'(a), 1);
        rbyte(b, 1'b1);
        chk("R6 pointer kept", int'(b), int'(exp_reg[6]));
        bus_stop();

        // R7: chip-select low
        bus_sel = 1'b0;
        tick(4);
        txb[0] = 8'h11;
        wr_txn(7'h05, 8'd0, 1, acks);
        chk("R7 no acks", acks, 0);
        check_cfg("R7 cfg unchanged");
        bus_sel = 1'b1;
        tick(4);

        // R8: sleep in the middle of a transaction
        bus_start();
        wbyte({7'h05, 1'b0}, a);
        wbyte(8'd0, a);
        sleep_n = 1'b0;
        tick(3);
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
        chk("R8 oe in sleep", int'(sda_oe), 0);
        check_cfg("R8 cfg cleared");
        sleep_n = 1'b1;
        tick(3);
        bus_stop();
        txb[0] = 8'h7E;
        exp_reg[4] = 8'h7E;
        wr_txn(7'h05, 8'd4, 1, acks);
        chk("R8 usable after sleep", acks, 3);
        check_cfg("R8 R3 cfg after sleep");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule